// File: doc/BRIEF.md
# Quadrature Sine/Cosine Tone Generator

This block produces a sine sample and a cosine sample of the same frequency on every clock. The two are held exactly a quarter turn apart, which suits digital up- and down-conversion. A 32-bit phase accumulator advances by a programmable frequency word on every cycle. The tone frequency is therefore Fclk × word / 2^32. For example, a word of 0x028F5C28 at a 100 MHz clock yields 1 MHz, or 100 samples per period.

A load request sets the accumulator to a programmable start phase. This gives several generators a known phase relation, such as a half turn, which is 0x80000000. The upper 13 accumulator bits select one of 8192 points of a full sine period. Both outputs are 14-bit signed two's-complement samples that can feed a converter directly.

Only a quarter of the period is stored. The other three quarters are produced by mirroring the index and negating the result. The cosine lookup uses the same accumulator value advanced by 0x40000000. Both paths therefore have the same fixed latency.

Top module: `quad_nco`

## Requirements
- R1: Each cycle without a load, the phase accumulator adds the registered frequency word, wrapping modulo 2^32.
- R2: The load request, start phase and frequency word are registered once before they affect the accumulator, so a load does not show on the outputs earlier than the fourth clock edge after the request is sampled.
- R3: While the registered load request is high, the accumulator takes the registered start phase instead of accumulating.
- R4: The sine output for accumulator value P is sample k = P[31:19], with value sin(2π·k/8192)·8192 rounded to nearest (halves away from zero) and saturated to −8192..+8191, as 14-bit two's complement.
- R5: The cosine output is the sample for P + 0x40000000, i.e. table index (k + 2048) mod 8192, taken from the same accumulator value as the sine.
- R6: The sample for the phase that a load installs appears on both outputs on exactly the fourth clock edge after the load request is sampled, and one new sample follows every clock after that.
- R7: A low rst_n at a clock edge clears the accumulator, the start-phase and frequency registers and both outputs to zero, and sets the registered load request to one.
- R8: The positive peak (index 2048) saturates to +8191, while the negative peak (index 6144) reaches −8192.
- R9: With a zero frequency word, both outputs stay constant at the samples for the loaded phase.
- R10: Both outputs always lie near the unit circle, with sin² + cos² within 40000 of 8192².

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_req | input | 1 | Request to load the start phase into the accumulator |
| start_phase | input | 32 | Phase installed by a load (2^32 = one turn) |
| freq_word | input | 32 | Phase increment added per clock |
| sin_out | output | 14 | Signed sine sample |
| cos_out | output | 14 | Signed cosine sample |

## Verification
The assertions check the following on every cycle:
- the accumulator steps by the registered word, or takes the registered start phase under a load;
- reset leaves the cleared state with the load request pending;
- the two outputs never leave the band around the unit circle.

Exact sample values, the rounding and saturation of the peaks, the four-edge load latency and the 2048-step relation between cosine and sine need a reference model. Only the bench's directed scenarios can show those.

// File: rtl/quad_nco_pkg.sv
// Package: shared constants and the elaboration-time sine function.
// Assumes the table covers one quarter turn, i.e. indices 0 .. 2^(addr_w-2).
package quad_nco_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Magnitude of the sine at full-period index idx, scaled to 2^(samp_w-1),
    // rounded to nearest. The value 2^(samp_w-1) itself is returned unsaturated.
    function automatic int quarter_mag(input int idx, input int addr_w, input int samp_w);
        real ang;
        real val;
        ang = TWO_PI * real'(idx) / real'(2 ** addr_w);
        val = $sin(ang) * real'(2 ** (samp_w - 1));
        return $rtoi(val + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
// Phase accumulator with registered controls.
// Registers load request, start phase and frequency word once; then either
// installs the start phase or adds the frequency word (modulo 2^PHASE_W).
// Assumes a synchronous active-low reset; reset leaves a load pending.
module nco_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_req,
    input  logic [PHASE_W-1:0] start_phase,
    input  logic [PHASE_W-1:0] freq_word,
    output logic               load_q,
    output logic [PHASE_W-1:0] start_q,
    output logic [PHASE_W-1:0] fcw_q,
    output logic [PHASE_W-1:0] phase_q
);

    // Capture the control inputs one cycle ahead of their use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= 1'b1;
            start_q <= '0;
            fcw_q   <= '0;
        end else begin
            load_q  <= load_req;
            start_q <= start_phase;
            fcw_q   <= freq_word;
        end
    end

    // Load or advance the phase accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (load_q) begin
            phase_q <= start_q;
        end else begin
            phase_q <= phase_q + fcw_q;
        end
    end

endmodule

// File: rtl/nco_quarter_rom.sv
// Quarter-wave magnitude table with a registered read port.
// Holds 2^(ADDR_W-2)+1 unsigned magnitudes computed at elaboration.
// No reset on the read register, so it can map onto block memory.
module nco_quarter_rom #(
    parameter int ADDR_W   = 13,
    parameter int SAMPLE_W = 14,
    localparam int QDEPTH  = 2 ** (ADDR_W - 2),
    localparam int IDX_W   = ADDR_W - 1
) (
    input  logic                clk,
    input  logic [IDX_W-1:0]    idx,
    output logic [SAMPLE_W-1:0] mag
);

    logic [SAMPLE_W-1:0] table_w [0:QDEPTH];

    // Fill every entry from the constant function.
    for (genvar k = 0; k <= QDEPTH; k++) begin : g_entry
        localparam int MAGV = quad_nco_pkg::quarter_mag(k, ADDR_W, SAMPLE_W);
        assign table_w[k] = MAGV[SAMPLE_W-1:0];
    end

    // Registered table read.
    always_ff @(posedge clk) begin
        mag <= table_w[idx];
    end

endmodule

// File: rtl/nco_wave_lookup.sv
// Phase-to-amplitude converter for one output channel.
// Stage 1 folds the full-period address into a quarter index plus sign.
// Stage 2 reads the quarter table. Stage 3 applies the sign and the
// positive saturation. Latency is three clocks from addr to sample_out.
// Only the output stage is reset.
module nco_wave_lookup #(
    parameter int ADDR_W   = 13,
    parameter int SAMPLE_W = 14,
    localparam int QDEPTH  = 2 ** (ADDR_W - 2),
    localparam int IDX_W   = ADDR_W - 1,
    localparam int LOW_W   = ADDR_W - 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    output logic signed [SAMPLE_W-1:0] sample_out
);

    localparam logic [SAMPLE_W-1:0] MAXPOS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [1:0]          quad;
    logic [LOW_W-1:0]    low;
    logic [IDX_W-1:0]    idx_d;
    logic [IDX_W-1:0]    idx_s1;
    logic                neg_s1;
    logic                neg_s2;
    logic [SAMPLE_W-1:0] mag_s2;

    assign quad = addr[ADDR_W-1 -: 2];
    assign low  = addr[LOW_W-1:0];

    // Mirror the index in the second and fourth quarters.
    always_comb begin
        if (quad[0]) begin
            idx_d = IDX_W'(QDEPTH) - {1'b0, low};
        end else begin
            idx_d = {1'b0, low};
        end
    end

    // Stage 1: registered folded address and sign.
    always_ff @(posedge clk) begin
        idx_s1 <= idx_d;
        neg_s1 <= quad[1];
    end

    nco_quarter_rom #(
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_rom (
        .clk (clk),
        .idx (idx_s1),
        .mag (mag_s2)
    );

    // Stage 2: carry the sign alongside the table read.
    always_ff @(posedge clk) begin
        neg_s2 <= neg_s1;
    end

    // Stage 3: apply the sign, or saturate the positive peak.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
        end else if (neg_s2) begin
            sample_out <= signed'(~mag_s2 + 1'b1);
        end else if (mag_s2[SAMPLE_W-1]) begin
            sample_out <= signed'(MAXPOS);
        end else begin
            sample_out <= signed'(mag_s2);
        end
    end

endmodule

// File: rtl/quad_nco.sv
// Quadrature sine/cosine tone generator (top).
// One phase accumulator feeds two identical lookup channels: channel 0 takes
// the phase as is (sine), channel 1 takes it advanced by a quarter turn
// (cosine). Both share the same pipeline depth.
module quad_nco #(
    parameter int PHASE_W  = 32,
    parameter int ADDR_W   = 13,
    parameter int SAMPLE_W = 14,
    localparam int NCH     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_req,
    input  logic [PHASE_W-1:0]         start_phase,
    input  logic [PHASE_W-1:0]         freq_word,
    output logic signed [SAMPLE_W-1:0] sin_out,
    output logic signed [SAMPLE_W-1:0] cos_out
);

    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

    logic                       load_q;
    logic [PHASE_W-1:0]         start_q;
    logic [PHASE_W-1:0]         fcw_q;
    logic [PHASE_W-1:0]         phase_q;
    logic signed [SAMPLE_W-1:0] chan_out [NCH];

    nco_phase_acc #(
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_req    (load_req),
        .start_phase (start_phase),
        .freq_word   (freq_word),
        .load_q      (load_q),
        .start_q     (start_q),
        .fcw_q       (fcw_q),
        .phase_q     (phase_q)
    );

    // One lookup channel per output; channel 1 is offset by a quarter turn.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [PHASE_W-1:0] ch_phase;
        if (ch == 0) begin : g_sin
            assign ch_phase = phase_q;
        end else begin : g_cos
            assign ch_phase = phase_q + QUARTER;
        end
        nco_wave_lookup #(
            .ADDR_W   (ADDR_W),
            .SAMPLE_W (SAMPLE_W)
        ) u_lookup (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr       (ch_phase[PHASE_W-1 -: ADDR_W]),
            .sample_out (chan_out[ch])
        );
    end

    assign sin_out = chan_out[0];
    assign cos_out = chan_out[1];

endmodule

// File: rtl/quad_nco_checker.sv
// Cycle-level checks for quad_nco, attached by bind. A fill counter keeps
// the checks off values left over from reset and from the unreset pipeline.
module quad_nco_checker #(
    parameter int PHASE_W  = 32,
    parameter int SAMPLE_W = 14,
    parameter int TOL      = 40000
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load_q,
    input logic [PHASE_W-1:0]         start_q,
    input logic [PHASE_W-1:0]         fcw_q,
    input logic [PHASE_W-1:0]         phase_q,
    input logic signed [SAMPLE_W-1:0] sin_out,
    input logic signed [SAMPLE_W-1:0] cos_out
);

    localparam int RADSQ = 2 ** (2 * (SAMPLE_W - 1));

    logic [1:0] fill;
    int         pow_sum;

    // Count clean edges since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (fill != 2'd3) begin
            fill <= fill + 2'd1;
        end
    end

    assign pow_sum = int'(sin_out) * int'(sin_out) + int'(cos_out) * int'(cos_out);

    AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != 2'd0 && !$past(load_q)) |-> (phase_q == $past(phase_q) + $past(fcw_q))); // R1

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != 2'd0 && $past(load_q)) |-> (phase_q == $past(start_q))); // R3

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (phase_q == '0 && start_q == '0 && fcw_q == '0 && load_q
                    && sin_out == '0 && cos_out == '0)); // R7

    AST_UNIT_CIRCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 2'd3) |-> (pow_sum > RADSQ - TOL && pow_sum < RADSQ + TOL)); // R10

endmodule

bind quad_nco quad_nco_checker #(
    .PHASE_W  (PHASE_W),
    .SAMPLE_W (SAMPLE_W)
) u_quad_nco_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_q  (load_q),
    .start_q (start_q),
    .fcw_q   (fcw_q),
    .phase_q (phase_q),
    .sin_out (sin_out),
    .cos_out (cos_out)
);

// File: tb/quad_nco_bench.sv
`timescale 1ns/1ps
// Directed bench for quad_nco: one task per scenario, each checking itself.
module quad_nco_bench;

    localparam real PI2 = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load_req = 1'b0;
    logic [31:0]        start_phase = '0;
    logic [31:0]        freq_word = '0;
    logic signed [13:0] sin_out;
    logic signed [13:0] cos_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    quad_nco u_quad_nco (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_req    (load_req),
        .start_phase (start_phase),
        .freq_word   (freq_word),
        .sin_out     (sin_out),
        .cos_out     (cos_out)
    );

    // Reference sample for a 32-bit phase, following R4.
    function automatic int ref_sample(input logic [31:0] ph);
        int  k;
        int  r;
        real v;
        k = int'(ph[31:19]);
        v = $sin(PI2 * real'(k) / 8192.0) * 8192.0;
        if (v >= 0.0) r = $rtoi(v + 0.5);
        else          r = -$rtoi(-v + 0.5);
        if (r > 8191)  r = 8191;
        if (r < -8192) r = -8192;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse a load, then compare the output stream to the model.
    task automatic run_stream(input logic [31:0] s, input logic [31:0] f,
                              input int n, input string req);
        logic [31:0] p;
        @(negedge clk);
        start_phase = s;
        freq_word   = f;
        load_req    = 1'b1;
        @(negedge clk);
        load_req    = 1'b0;
        repeat (3) @(negedge clk);
        p = s;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({req, " sin"}, int'(sin_out), ref_sample(p));
            check({req, " cos"}, int'(cos_out), ref_sample(p + 32'h4000_0000));
            p = p + f;
        end
    endtask

    // R7: reset clears outputs; after release phase 0 gives sin 0, cos +8191.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 sin in reset", int'(sin_out), 0);
        check("R7 cos in reset", int'(cos_out), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 sin after reset", int'(sin_out), 0);
        check("R5 cos after reset", int'(cos_out), 8191);
    endtask

    // R8: peak saturation and the full negative peak.
    task automatic t_peaks();
        run_stream(32'h4000_0000, 32'h0, 1, "R8 quarter");
        check("R8 sin +peak", int'(sin_out), 8191);
        check("R8 cos at half", int'(cos_out), 0);
        run_stream(32'hC000_0000, 32'h0, 1, "R8 three quarter");
        check("R8 sin -peak", int'(sin_out), -8192);
        run_stream(32'h8000_0000, 32'h0, 1, "R8 half");
        check("R8 cos -peak", int'(cos_out), -8192);
    endtask

    // R2, R6: new phase absent at edge 3 after the request, present at edge 4.
    task automatic t_latency();
        run_stream(32'h2000_0000, 32'h0, 2, "R3 settle");
        @(negedge clk);
        start_phase = 32'h6000_0000;
        load_req    = 1'b1;
        @(negedge clk);
        load_req    = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 old phase at edge 3", int'(sin_out), ref_sample(32'h2000_0000));
        @(negedge clk);
        check("R6 new phase at edge 4", int'(sin_out), ref_sample(32'h6000_0000));
        check("R6 new cos at edge 4", int'(cos_out), ref_sample(32'hA000_0000));
    endtask

    // R9: zero word holds both outputs.
    task automatic t_hold();
        run_stream(32'h3141_5926, 32'h0, 1, "R9 load");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R9 sin held", int'(sin_out), ref_sample(32'h3141_5926));
            check("R9 cos held", int'(cos_out), ref_sample(32'h7141_5926));
        end
    endtask

    // R5: one table step per clock; cos(n) must equal sin(n + 2048).
    task automatic t_quadrature();
        int sin_h [2200];
        int cos_h [2200];
        @(negedge clk);
        start_phase = 32'h0;
        freq_word   = 32'h0008_0000;
        load_req    = 1'b1;
        @(negedge clk);
        load_req    = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2200; i++) begin
            @(negedge clk);
            sin_h[i] = int'(sin_out);
            cos_h[i] = int'(cos_out);
        end
        for (int i = 0; i < 100; i++) begin
            check("R5 cos vs sin+2048", cos_h[i], sin_h[i + 2048]);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_peaks();
        t_latency();
        run_stream(32'h0, 32'h028F_5C28, 150, "R1 R4 1MHz word");
        run_stream(32'h8000_0000, 32'h028F_5C28, 50, "R3 half turn start");
        run_stream(32'hFFFF_0000, 32'h0010_0000, 100, "R1 wrap");
        run_stream(32'h1234_5678, 32'h9ABC_DEF1, 200, "R4 large step");
        t_hold();
        t_quadrature();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule